// File: doc/BRIEF.md
# Three-State PWM Command Decoder

This block sits between a set of external window comparators and a half-bridge gate-drive sequencer. The comparators watch a single three-level PWM command line. One flag says the line is above the upper threshold, one says it is below the lower threshold, and one says it sits inside the mid-level window. The block turns these flags into one clean request per cycle: drive the high-side switch, drive the low-side switch, or shut both off.

A mid-level input does not shut the stage down at once. It must stay in the window for a hold-off time before the decoder declares shutdown. A brief pass through the window on the way between the two rails is therefore ignored. The hold-off time and the minimum low-pulse width are given in nanoseconds together with the clock period, and are rounded up to whole clock cycles. A low command must last at least the minimum off time before a high level is accepted.

When the input leaves shutdown, the decoder moves straight to the commanded switch. It also raises a one-cycle exit strobe, so the sequencer knows the opposite switch is already off and can skip its break-before-make wait. After reset the decoder is in shutdown, so the first valid level also produces that strobe.

Top module: `tristate_pwm_decoder`

## Requirements
- R1: While reset is held, and in the first cycle after it, `shutdown` is 1 and `hsReq`, `lsReq` and `exitPulse` are 0.
- R2: The flags are resolved with a fixed priority: `cmpHigh` set means a high level, whatever the other flags show. Otherwise `cmpLow` set means a low level. Otherwise `cmpMid` set means a window level. No flag set means a gap level.
- R3: In every cycle out of reset, exactly one of `hsReq`, `lsReq` and `shutdown` is 1.
- R4: `shutdown` rises at the clock edge that samples the HOLD-th consecutive window level. HOLD is 40 cycles by default: 160 ns at a 4 ns clock, rounded up. It never rises earlier.
- R5: A high or low level sampled before the hold-off expires restarts the window count. The current command is kept unless that level itself changes it.
- R6: A gap level (no flag set) keeps the current command and also restarts the window count.
- R7: In shutdown, a low level moves the decoder to `lsReq` at the sampling edge.
- R8: In shutdown, a high level moves the decoder to `hsReq` at the sampling edge.
- R9: Once `lsReq` is entered from `hsReq` or from shutdown, a high level is not accepted until MINOFF edges have passed. MINOFF is 30 cycles by default: 120 ns, rounded up. The high command is taken at the MINOFF-th edge after entry.
- R10: `exitPulse` is 1 for exactly the one cycle in which the decoder has just left shutdown, and 0 in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmpHigh | input | 1 | Input is above the upper threshold |
| cmpLow | input | 1 | Input is below the lower threshold |
| cmpMid | input | 1 | Input is inside the mid-level window |
| hsReq | output | 1 | Request to turn on the high-side switch |
| lsReq | output | 1 | Request to turn on the low-side switch |
| shutdown | output | 1 | Both switches are requested off |
| exitPulse | output | 1 | One-cycle strobe on leaving shutdown |

## Verification
The bound checker covers the properties that hold in every cycle:
- exactly one request is active;
- shutdown rises only after a full hold-off run of window levels;
- a high request never directly follows a low request that was shorter than the minimum off time;
- the exit strobe appears exactly once per departure from shutdown.

The bench scenarios cover what the checker cannot show:
- a window run that is one cycle short leaves the command untouched;
- a gap or rail level in the middle of a window run restarts the count;
- the flag priority holds when several flags are set at once;
- a blocked high level is taken at exactly the right edge once the minimum off time is over.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

  // Registered command held by the control block
  typedef enum logic [1:0] {
    CMD_OFF  = 2'd0,
    CMD_HIGH = 2'd1,
    CMD_LOW  = 2'd2
  } cmd_e;

  // Resolved input level after flag priority
  typedef enum logic [1:0] {
    LVL_GAP  = 2'd0,
    LVL_HIGH = 2'd1,
    LVL_LOW  = 2'd2,
    LVL_MID  = 2'd3
  } lvl_e;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic midInc;
    logic midClr;
    logic lowLoad;
    logic lowInc;
  } strobe_t;

  // Round a duration in ns up to whole cycles, never below one
  function automatic int nsToCycles(input int durNs, input int periodPs);
    int cyc;
    cyc = (durNs * 1000 + periodPs - 1) / periodPs;
    return (cyc < 1) ? 1 : cyc;
  endfunction

endpackage

// File: rtl/tpd_datapath.sv
module tpd_datapath
  import tpd_pkg::*;
#(
  parameter int HOLD_CYC   = 40,
  parameter int MINOFF_CYC = 30
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  output logic    holdDone,
  output logic    minOffDone
);

  localparam int MID_W = (HOLD_CYC   > 1) ? $clog2(HOLD_CYC + 1)   : 1;
  localparam int LOW_W = (MINOFF_CYC > 1) ? $clog2(MINOFF_CYC + 1) : 1;
  localparam logic [MID_W-1:0] MID_LAST = MID_W'(HOLD_CYC - 1);
  localparam logic [LOW_W-1:0] LOW_FULL = LOW_W'(MINOFF_CYC);
  localparam logic [LOW_W-1:0] LOW_ONE  = LOW_W'(1);

  logic [MID_W-1:0] midCnt;
  logic [LOW_W-1:0] lowCnt;

  // Consecutive window samples, saturating at the last hold-off step
  always_ff @(posedge clk) begin
    if (!rstN) begin
      midCnt <= '0;
    end else if (stb.midClr) begin
      midCnt <= '0;
    end else if (stb.midInc && (midCnt != MID_LAST)) begin
      midCnt <= midCnt + 1'b1;
    end
  end

  // Age of the current low command, saturating at the minimum off time
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (stb.lowLoad) begin
      lowCnt <= LOW_ONE;
    end else if (stb.lowInc && (lowCnt != LOW_FULL)) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  assign holdDone   = (midCnt == MID_LAST);
  assign minOffDone = (lowCnt == LOW_FULL);

endmodule

// File: rtl/tpd_control.sv
module tpd_control
  import tpd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmpHigh,
  input  logic    cmpLow,
  input  logic    cmpMid,
  input  logic    holdDone,
  input  logic    minOffDone,
  output strobe_t stb,
  output cmd_e    cmdQ,
  output logic    exitQ
);

  lvl_e lvl;
  cmd_e cmdNext;
  logic exitNext;

  // Flag priority: upper rail, then lower rail, then window
  always_comb begin
    if (cmpHigh)     lvl = LVL_HIGH;
    else if (cmpLow) lvl = LVL_LOW;
    else if (cmpMid) lvl = LVL_MID;
    else             lvl = LVL_GAP;
  end

  always_comb begin
    cmdNext  = cmdQ;
    exitNext = 1'b0;
    unique case (cmdQ)
      CMD_OFF: begin
        if (lvl == LVL_HIGH) begin
          cmdNext  = CMD_HIGH;
          exitNext = 1'b1;
        end else if (lvl == LVL_LOW) begin
          cmdNext  = CMD_LOW;
          exitNext = 1'b1;
        end
      end
      CMD_HIGH: begin
        if (lvl == LVL_LOW) begin
          cmdNext = CMD_LOW;
        end else if ((lvl == LVL_MID) && holdDone) begin
          cmdNext = CMD_OFF;
        end
      end
      CMD_LOW: begin
        if ((lvl == LVL_HIGH) && minOffDone) begin
          cmdNext = CMD_HIGH;
        end else if ((lvl == LVL_MID) && holdDone) begin
          cmdNext = CMD_OFF;
        end
      end
      default: cmdNext = CMD_OFF;
    endcase
  end

  always_comb begin
    stb.midInc  = (lvl == LVL_MID);
    stb.midClr  = (lvl != LVL_MID);
    stb.lowLoad = (cmdNext == CMD_LOW) && (cmdQ != CMD_LOW);
    stb.lowInc  = (cmdQ == CMD_LOW);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ  <= CMD_OFF;
      exitQ <= 1'b0;
    end else begin
      cmdQ  <= cmdNext;
      exitQ <= exitNext;
    end
  end

endmodule

// File: rtl/tristate_pwm_decoder.sv
module tristate_pwm_decoder
  import tpd_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 4000,
  parameter int HOLDOFF_NS    = 160,
  parameter int MINOFF_NS     = 120
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmpHigh,
  input  logic cmpLow,
  input  logic cmpMid,
  output logic hsReq,
  output logic lsReq,
  output logic shutdown,
  output logic exitPulse
);

  localparam int HOLD_CYC   = nsToCycles(HOLDOFF_NS, CLK_PERIOD_PS);
  localparam int MINOFF_CYC = nsToCycles(MINOFF_NS, CLK_PERIOD_PS);

  strobe_t stb;
  cmd_e    cmdQ;
  logic    exitQ;
  logic    holdDone;
  logic    minOffDone;

  tpd_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmpHigh    (cmpHigh),
    .cmpLow     (cmpLow),
    .cmpMid     (cmpMid),
    .holdDone   (holdDone),
    .minOffDone (minOffDone),
    .stb        (stb),
    .cmdQ       (cmdQ),
    .exitQ      (exitQ)
  );

  tpd_datapath #(
    .HOLD_CYC   (HOLD_CYC),
    .MINOFF_CYC (MINOFF_CYC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .holdDone   (holdDone),
    .minOffDone (minOffDone)
  );

  assign hsReq     = (cmdQ == CMD_HIGH);
  assign lsReq     = (cmdQ == CMD_LOW);
  assign shutdown  = (cmdQ == CMD_OFF);
  assign exitPulse = exitQ;

endmodule

// File: rtl/tristate_pwm_decoder_chk.sv
module tristate_pwm_decoder_chk #(
  parameter int HOLD_CYC   = 40,
  parameter int MINOFF_CYC = 30
) (
  input logic clk,
  input logic rstN,
  input logic cmpHigh,
  input logic cmpLow,
  input logic cmpMid,
  input logic hsReq,
  input logic lsReq,
  input logic shutdown,
  input logic exitPulse
);

  logic        midLvl;
  logic [31:0] midRun;
  logic [31:0] lowRun;

  assign midLvl = cmpMid && !cmpHigh && !cmpLow;

  // Independent run-length counters, saturating at their limits
  always_ff @(posedge clk) begin
    if (!rstN) begin
      midRun <= '0;
    end else if (!midLvl) begin
      midRun <= '0;
    end else if (midRun < 32'(HOLD_CYC)) begin
      midRun <= midRun + 32'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowRun <= '0;
    end else if (!lsReq) begin
      lowRun <= '0;
    end else if (lowRun < 32'(MINOFF_CYC)) begin
      lowRun <= lowRun + 32'd1;
    end
  end

  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    $countones({hsReq, lsReq, shutdown}) == 1); // R3

  AST_SHUTDOWN_AFTER_HOLDOFF: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shutdown) |-> (midRun >= 32'(HOLD_CYC))); // R4

  AST_SHUTDOWN_FROM_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shutdown) |-> $past(midLvl)); // R4

  AST_LOW_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(hsReq) && $past(lsReq)) |-> (lowRun >= 32'(MINOFF_CYC))); // R9

  AST_HIGH_EXIT_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(hsReq) && $past(shutdown)) |-> $past(cmpHigh)); // R8

  AST_EXIT_ON_LEAVE: assert property (@(posedge clk) disable iff (!rstN)
    exitPulse |-> ($past(shutdown) && !shutdown)); // R10

  AST_LEAVE_GIVES_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(shutdown) |-> exitPulse); // R10

  AST_EXIT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    exitPulse |=> !exitPulse); // R10

endmodule

bind tristate_pwm_decoder tristate_pwm_decoder_chk #(
  .HOLD_CYC   (HOLD_CYC),
  .MINOFF_CYC (MINOFF_CYC)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmpHigh   (cmpHigh),
  .cmpLow    (cmpLow),
  .cmpMid    (cmpMid),
  .hsReq     (hsReq),
  .lsReq     (lsReq),
  .shutdown  (shutdown),
  .exitPulse (exitPulse)
);

// File: tb/tristate_pwm_decoder_tb.sv
module tristate_pwm_decoder_tb;

  localparam int PERIOD_PS = 4000;
  localparam int HOLD      = (160 * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int MINOFF    = (120 * 1000 + PERIOD_PS - 1) / PERIOD_PS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmpHigh = 1'b0;
  logic cmpLow = 1'b0;
  logic cmpMid = 1'b0;
  logic hsReq, lsReq, shutdown, exitPulse;

  always #2 clk = ~clk;

  tristate_pwm_decoder u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .cmpHigh   (cmpHigh),
    .cmpLow    (cmpLow),
    .cmpMid    (cmpMid),
    .hsReq     (hsReq),
    .lsReq     (lsReq),
    .shutdown  (shutdown),
    .exitPulse (exitPulse)
  );

  typedef struct {
    logic [2:0] req;
    logic       ex;
    string      tag;
  } item_t;

  item_t expQ[$];
  int    checks = 0;
  int    fails  = 0;
  string curReq = "R1";
  bit    done   = 1'b0;

  // Expected-behaviour model state: 0 off, 1 high, 2 low
  int mCmd = 0;
  int mMid = 0;
  int mAge = 0;

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: apply one input sample and push the expected result of that edge
  task automatic step(input bit h, input bit l, input bit m);
    item_t it;
    bit    ex;
    int    lvl;
    @(negedge clk);
    cmpHigh = h;
    cmpLow  = l;
    cmpMid  = m;
    ex = 1'b0;
    lvl = h ? 1 : (l ? 2 : (m ? 3 : 0));
    if (lvl == 3) begin
      mMid++;
      if (mMid >= HOLD && mCmd != 0) mCmd = 0;
    end else begin
      mMid = 0;
    end
    if (lvl == 1) begin
      if (mCmd == 0) begin mCmd = 1; ex = 1'b1; end
      else if (mCmd == 2 && mAge >= MINOFF) mCmd = 1;
    end else if (lvl == 2) begin
      if (mCmd == 0) begin mCmd = 2; ex = 1'b1; mAge = 0; end
      else if (mCmd == 1) begin mCmd = 2; mAge = 0; end
    end
    if (mCmd == 2) mAge++;
    it.req = (mCmd == 1) ? 3'b100 : ((mCmd == 2) ? 3'b010 : 3'b001);
    it.ex  = ex;
    it.tag = curReq;
    expQ.push_back(it);
  endtask

  task automatic run(input bit h, input bit l, input bit m, input int n);
    for (int i = 0; i < n; i++) step(h, l, m);
  endtask

  // Monitor: compare one result per edge, sampled 1 ns after the edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (rstN && expQ.size() > 0) begin
        it = expQ.pop_front();
        check(it.tag, {hsReq, lsReq, shutdown, 1'b0}, {it.req, 1'b0});
        check("R10", {3'b000, exitPulse}, {3'b000, it.ex});
        check("R3", {3'b000, ($countones({hsReq, lsReq, shutdown}) == 1)}, 4'b0001);
      end
    end
  end

  task automatic finishRun;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    // R1: reset state, while reset is held and in the first cycle after
    repeat (3) @(posedge clk);
    #1;
    check("R1", {hsReq, lsReq, shutdown, exitPulse}, 4'b0010);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check("R1", {hsReq, lsReq, shutdown, exitPulse}, 4'b0010);

    // Exit from shutdown towards high
    curReq = "R8";
    run(1, 0, 0, 3);

    // Flag priority with several flags set at once
    curReq = "R2";
    run(1, 1, 1, 2);
    run(0, 1, 1, MINOFF + 2);
    run(1, 1, 1, 3);

    // High level blocked until the low command is old enough
    curReq = "R9";
    run(0, 1, 0, 1);
    run(1, 0, 0, MINOFF + 3);

    // Window runs one short, broken by a rail level
    curReq = "R5";
    run(0, 0, 1, HOLD - 1);
    run(1, 0, 0, 2);
    run(0, 0, 1, HOLD - 1);
    run(0, 1, 0, 1);
    run(0, 0, 1, HOLD - 1);
    run(0, 1, 0, 2);

    // Gap level keeps the command and restarts the count
    curReq = "R6";
    run(0, 0, 1, HOLD / 2);
    run(0, 0, 0, 3);
    run(0, 0, 1, HOLD - 1);
    run(0, 0, 0, 2);

    // Full hold-off gives shutdown, from the low command
    curReq = "R4";
    run(0, 0, 1, HOLD + 3);

    // Exit from shutdown towards low
    curReq = "R7";
    run(0, 1, 0, 4);

    // Shutdown again, then leave towards high
    curReq = "R4";
    run(0, 0, 1, HOLD);
    run(0, 0, 0, 2);
    curReq = "R8";
    run(1, 0, 0, 3);

    // Shutdown from the high command, then gap keeps shutdown
    curReq = "R4";
    run(0, 0, 1, HOLD + 1);
    curReq = "R6";
    run(0, 0, 0, 3);

    @(negedge clk);
    cmpHigh = 1'b0;
    cmpLow  = 1'b0;
    cmpMid  = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    done = 1'b1;
    finishRun();
  end

endmodule